// File: doc/BRIEF.md
# Segment/GPIO Pin Function Controller

This block controls a bank of shared pins. Each pin can act as an LCD segment output or as a general-purpose digital pin. A per-pin map bit picks the function. When a pin is in digital mode, a per-pin direction bit picks input or output. A per-pin data bit supplies the value the pin drives. The block produces the segment-select, output-enable and output-data signals for the pad ring, and it returns the masked pad inputs for readback. Segment waveform generation and the pad cells are handled elsewhere.

The lowest pins (16 by default) come out of reset configured as outputs. A single port-enable bit keeps their drivers off, so no stray pulses appear while software sets them up. Software writes the configuration and then sets port-enable to let those pins drive. All other pins come out of reset as inputs, and port-enable has no effect on them. The dedicated push-button input is not part of this bank.

Configuration is written one 8-bit word per cycle through `wr_addr`/`wr_data`. `wr_addr[3:2]` selects the register kind: 0 = map, 1 = direction, 2 = output data, 3 = control. `wr_addr[1:0]` selects which group of 8 pins the write covers: word w covers pins 8w..8w+7, with data bit b going to pin 8w+b. A write takes effect on the clock edge where `wr_en` is sampled high.

Top module: `segio_pinctl`

## Requirements
- R1: Reset state:
  - all map bits are 0;
  - direction is output for pins 0..15 and input for all other pins;
  - all data bits are 0;
  - port-enable is 0.
  
  So after reset `pad_oe`, `pad_do` and `seg_en` are all zero.
- R2: A pin whose map bit is 1 has `seg_en` high, `pad_oe` low and `in_val` 0, whatever its direction and pad input.
- R3: A pin whose map bit is 0 reports its `pad_in` value on `in_val`.
- R4: For pins 0..15, `pad_oe` is high exactly when the direction bit is 1, the map bit is 0 and port-enable is 1.
- R5: For pins 16 and above, `pad_oe` is high exactly when the direction bit is 1 and the map bit is 0, independent of port-enable.
- R6: A write to a map, direction or data word changes only the 8 pins of that word, and each pin's direction is set independently.
- R7: `pad_do` equals the pin's data bit while `pad_oe` is high and is 0 otherwise.
- R8: A control write (kind 3) loads port-enable from `wr_data[0]`; the other data bits and the word field are ignored.
- R9: Without a write, the configuration, and therefore `pad_oe` and `seg_en`, holds from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | [3:2] register kind, [1:0] pin word |
| wr_data | input | 8 | Write data, one bit per pin of the word |
| pad_in | input | 32 | Input level seen at each pad |
| seg_en | output | 32 | Pin is in segment mode |
| pad_oe | output | 32 | Digital output driver enable |
| pad_do | output | 32 | Digital output value |
| in_val | output | 32 | Input readback, 0 for segment pins |

## Verification
A wrong map, direction or port-enable bit shows up on `pad_oe` and `seg_en` in the cycle after the write that set it. It stays visible until another write to the same word changes it. The port-enable gating only matters for the low 16 pins, so a gating fault shows up only when those pins and the upper pins are compared side by side. A fault in the readback masking appears at once on `in_val`, whenever `pad_in` differs from zero on a segment pin.

// File: rtl/segio_pinctl.sv
module segio_pinctl #(
  parameter int NPINS = 32,
  parameter int NLOW  = 16,
  parameter int WW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [3:0]          wr_addr,
  input  logic [WW-1:0]       wr_data,
  input  logic [NPINS-1:0]    pad_in,
  output logic [NPINS-1:0]    seg_en,
  output logic [NPINS-1:0]    pad_oe,
  output logic [NPINS-1:0]    pad_do,
  output logic [NPINS-1:0]    in_val
);
  localparam int NWORDS = NPINS / WW;
  localparam logic [NPINS-1:0] LOW_MASK = ~({NPINS{1'b1}} << NLOW);
  localparam logic [1:0] K_MAP = 2'd0, K_DIR = 2'd1, K_DAT = 2'd2, K_CTL = 2'd3;

  logic [NPINS-1:0] map_q, dir_q, dat_q;
  logic             pen_q;
  logic [1:0]       kind;
  logic [1:0]       widx;

  assign kind = wr_addr[3:2];
  assign widx = wr_addr[1:0];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_en && (widx == 2'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[w*WW +: WW] <= '0;
        dir_q[w*WW +: WW] <= LOW_MASK[w*WW +: WW];
        dat_q[w*WW +: WW] <= '0;
      end else if (hit) begin
        if (kind == K_MAP) map_q[w*WW +: WW] <= wr_data;
        if (kind == K_DIR) dir_q[w*WW +: WW] <= wr_data;
        if (kind == K_DAT) dat_q[w*WW +: WW] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pen_q <= 1'b0;
    else if (wr_en && kind == K_CTL)     pen_q <= wr_data[0];
  end

  assign seg_en = map_q;
  assign pad_oe = dir_q & ~map_q & (~LOW_MASK | {NPINS{pen_q}});
  assign pad_do = dat_q & pad_oe;
  assign in_val = pad_in & ~map_q;
endmodule

module segio_pinctl_chk #(
  parameter int NPINS = 32,
  parameter int NLOW  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] seg_en,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_do,
  input logic [NPINS-1:0] in_val
);
  assert_seg_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_en & pad_oe) == '0) && ((seg_en & in_val) == '0));

  assert_in_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_val | seg_en) == (pad_in | seg_en));

  assert_do_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_do & ~pad_oe) == '0);

  assert_reset_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && seg_en == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pad_oe) && $stable(seg_en)));
endmodule

bind segio_pinctl segio_pinctl_chk #(.NPINS(NPINS), .NLOW(NLOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pad_in(pad_in),
  .seg_en(seg_en), .pad_oe(pad_oe), .pad_do(pad_do), .in_val(in_val));

// File: tb/segio_pinctl_bench.sv
module segio_pinctl_bench;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [31:0] pad_in = 32'h0;
  logic [31:0] seg_en, pad_oe, pad_do, in_val;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  segio_pinctl u_segio_pinctl (.*);

  // {addr, data, expected pad_oe after the write}
  localparam int NV = 10;
  localparam logic [43:0] VEC [NV] = '{
    {4'hC, 8'h01, 32'h0000_FFFF},  // R8 R4 enable low pins
    {4'h0, 8'h0F, 32'h0000_FFF0},  // R2 R6 map word0
    {4'h6, 8'hA5, 32'h00A5_FFF0},  // R5 R6 dir word2
    {4'h7, 8'hFF, 32'hFFA5_FFF0},  // R5
    {4'h3, 8'h81, 32'h7EA5_FFF0},  // R2 map word3
    {4'hC, 8'h00, 32'h7EA5_0000},  // R4 R5 disable
    {4'h5, 8'h00, 32'h7EA5_0000},  // R6 dir word1
    {4'hC, 8'hFE, 32'h7EA5_0000},  // R8 upper bits ignored
    {4'hC, 8'h01, 32'h7EA5_00F0},  // R4 R8
    {4'h0, 8'h00, 32'h7EA5_00FF}   // R6 unmap word0
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    pad_in = 32'h5A5A_C3C3;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 oe", pad_oe, 32'h0);
    chk("R1 do", pad_do, 32'h0);
    chk("R1 seg", seg_en, 32'h0);
    chk("R3 in", in_val, 32'h5A5A_C3C3);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][43:40], VEC[i][39:32]);
      chk($sformatf("R4/R5/R6 vec%0d", i), pad_oe, VEC[i][31:0]);
    end

    chk("R2 seg", seg_en, 32'h8100_0000);
    pad_in = 32'hFFFF_FFFF;
    #1;
    chk("R2 R3 in", in_val, 32'h7EFF_FFFF);

    wr(4'h8, 8'h3C);
    chk("R7 do w0", pad_do, 32'h0000_003C);
    wr(4'hB, 8'hFF);
    chk("R7 do w3", pad_do, 32'h7E00_003C);
    wr(4'hA, 8'hFF);
    chk("R7 do w2", pad_do, 32'h7EA5_003C);
    wr(4'hC, 8'h00);
    chk("R7 gated low", pad_do, 32'h7EA5_0000);

    repeat (5) @(negedge clk);
    chk("R9 hold oe", pad_oe, 32'h7EA5_0000);
    chk("R9 hold seg", seg_en, 32'h8100_0000);

    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 oe again", pad_oe, 32'h0);
    chk("R1 seg again", seg_en, 32'h0);
    wr(4'hC, 8'h01);
    chk("R1 low dir out", pad_oe, 32'h0000_FFFF);
    chk("R1 data zero", pad_do, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule